// File: doc/BRIEF.md
# Low-Power Mode Controller with Oscillator-Settling Timer

This block owns an 8-bit system configuration register and the power-state sequencer of a small microcontroller. When the CPU raises a sleep request, the block parks the CPU in either a light sleep, where the clock keeps running, or a deep standby, where the oscillator is treated as stopped. The choice between the two comes from a register bit. While in deep standby, the external address bus and bus strobes are either released to high impedance or frozen. In the frozen case the address keeps its last driven value and the strobes stay inactive high.

Leaving deep standby takes an NMI edge of the configured polarity. That edge starts a down-counter loaded from an irregular table of oscillator-settling counts, and the CPU is released only when the count runs out. Reset also starts a settling wait, using the default code. Light sleep ends on the next clock after either an interrupt or an NMI edge. The block also exports the on-chip RAM enable, the mode flag for condition-code bit 6, and a sticky flag that records an illegal settling code.

Top module: `lpc_ctrl`

## Requirements
- R1: After reset the register reads 0x09, so `ram_en_o` and `user_bit_o` are 1 and `illegal_o` is 0. The CPU is then held (`cpu_run_o` = 0) for the settling wait of code 000 before it runs.
- R2: Register layout is: bit 7 standby select, bits 6:4 settling code, bit 3 user-bit mode (driven on `user_bit_o`), bit 2 NMI rising-edge select, bit 1 standby bus hold, bit 0 RAM enable (driven on `ram_en_o`). A write stores all eight bits, and they read back on `cfg_rdata_o` on the next cycle.
- R3: With bit 7 at 0, a sleep request taken while running sets `sleep_o` on the next clock. An interrupt in sleep resumes the CPU on the very next clock.
- R4: With bit 7 at 1, a sleep request enters standby (`stby_o` = 1, `cpu_run_o` = 0), and the only way out is an NMI edge.
- R5: The settling wait in clocks is the count for the code, shifted right by `SETTLE_SHIFT`. The counts are: 000 = 8192, 001 = 16384, 010 = 32768, 011 = 65536, 100 = 131072, 101 = 262144, 110 = 1024. From a standby NMI edge at the pin, `cpu_run_o` rises after the wait plus 3 clocks.
- R6: Code 111 uses the longest wait (262144 shifted) and sets `illegal_o`. The flag stays set until reset, even after a legal code is written.
- R7: `nmi_i` is synchronised through two flops. Bit 2 = 0 selects falling edges and 1 selects rising edges. A selected edge pulses `nmi_req_o` for one clock, 2 clocks after the pin change, and it wakes sleep 3 clocks after the change. The opposite edge is ignored.
- R8: In standby and in the settling wait, with bit 1 at 0, `bus_addr_oe_o` and `bus_strb_oe_o` are 0.
- R9: In standby and in the settling wait, with bit 1 at 1, `bus_addr_o` holds the address driven in the last running cycle whatever `cpu_addr_i` does. `bus_strb_o` is all ones, and both enables are 1.
- R10: Register writes are accepted only while the CPU runs. A write during sleep leaves the read-back value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_wdata_i | input | 8 | Register write data |
| cfg_rdata_o | output | 8 | Register read-back |
| illegal_o | output | 1 | Sticky illegal settling-code flag |
| sleep_req_i | input | 1 | CPU sleep request |
| wake_irq_i | input | 1 | Interrupt pending, wakes light sleep |
| nmi_i | input | 1 | Asynchronous NMI pin |
| nmi_req_o | output | 1 | One-clock NMI request pulse |
| cpu_run_o | output | 1 | CPU may execute |
| sleep_o | output | 1 | Light sleep active |
| stby_o | output | 1 | Deep standby active (oscillator stop) |
| ram_en_o | output | 1 | On-chip RAM enable |
| user_bit_o | output | 1 | 1: CCR bit 6 is a user bit; 0: interrupt mask |
| cpu_addr_i | input | ADDR_W | Address from CPU |
| cpu_strb_i | input | STB_W | Bus strobes from CPU |
| bus_addr_o | output | ADDR_W | Address to pins |
| bus_addr_oe_o | output | 1 | Address output enable |
| bus_strb_o | output | STB_W | Strobes to pins |
| bus_strb_oe_o | output | 1 | Strobe output enable |

## Verification
A settling counter loaded with the wrong value, or a state register stuck in standby, shows up on `cpu_run_o` as a release that comes one or more clocks early or late. That is visible by the end of the first wake. A fault in the edge detector or its synchroniser changes the fixed 2-clock and 3-clock latencies seen on `nmi_req_o` and `cpu_run_o`, or lets the opposite edge through, within a few clocks of the pin change. A broken address-hold register shows on `bus_addr_o` as soon as `cpu_addr_i` moves during standby.

// File: rtl/lpc_pkg.sv
`timescale 1ns/1ps
package lpc_pkg;
  localparam int CNT_W = 18;

  typedef enum logic [1:0] {ST_RUN, ST_SLEEP, ST_STBY, ST_SETTLE} lpc_state_e;

  typedef struct packed {
    logic       stby_sel;
    logic [2:0] settle_sel;
    logic       user_en;
    logic       nmi_rise;
    logic       hold_en;
    logic       ram_en;
  } lpc_cfg_t;

  // returns wait-1 so the counter ends at zero
  function automatic logic [CNT_W-1:0] settle_load(input logic [2:0] code,
                                                   input int unsigned shift);
    logic [CNT_W:0] base;
    logic [CNT_W:0] w;
    case (code)
      3'd0:    base = 19'd8192;
      3'd1:    base = 19'd16384;
      3'd2:    base = 19'd32768;
      3'd3:    base = 19'd65536;
      3'd4:    base = 19'd131072;
      3'd6:    base = 19'd1024;
      default: base = 19'd262144;
    endcase
    w = base >> shift;
    if (w == '0) w = 19'd1;
    w = w - 19'd1;
    return w[CNT_W-1:0];
  endfunction
endpackage

// File: rtl/lpc_sysreg.sv
`timescale 1ns/1ps
module lpc_sysreg
  import lpc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     we_i,
  input  logic [7:0] wdata_i,
  input  logic     wr_ok_i,
  output lpc_cfg_t cfg_o,
  output logic     illegal_o
);
  localparam logic [7:0] RST_VAL = 8'h09;

  lpc_cfg_t cfg_q;
  logic     illegal_q;
  logic     wr_acc;

  assign wr_acc = we_i & wr_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= lpc_cfg_t'(RST_VAL);
      illegal_q <= 1'b0;
    end else if (wr_acc) begin
      cfg_q <= lpc_cfg_t'(wdata_i);
      if (wdata_i[6:4] == 3'b111) illegal_q <= 1'b1;
    end
  end

  assign cfg_o     = cfg_q;
  assign illegal_o = illegal_q;

  // R6
  illegal_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_q |=> illegal_q);

  // R10
  wr_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ok_i |=> $stable(cfg_q));
endmodule

// File: rtl/lpc_nmi_edge.sv
`timescale 1ns/1ps
module lpc_nmi_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_i,
  input  logic rise_sel_i,
  output logic edge_o
);
  logic [1:0] sync_q;
  logic       prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], nmi_i};
      prev_q <= sync_q[1];
    end
  end

  assign edge_o = rise_sel_i ? (sync_q[1] & ~prev_q) : (~sync_q[1] & prev_q);

  // R7
  edge_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_o && $stable(rise_sel_i)) |=> !edge_o);
endmodule

// File: rtl/lpc_pwr_fsm.sv
`timescale 1ns/1ps
module lpc_pwr_fsm
  import lpc_pkg::*;
#(
  parameter int unsigned SETTLE_SHIFT = 0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sleep_req_i,
  input  logic       wake_irq_i,
  input  logic       nmi_edge_i,
  input  logic       stby_sel_i,
  input  logic [2:0] settle_sel_i,
  output lpc_state_e state_o,
  output logic       cpu_run_o
);
  localparam logic [CNT_W-1:0] RST_LOAD = settle_load(3'b000, SETTLE_SHIFT);

  lpc_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SETTLE;
      cnt_q   <= RST_LOAD;
    end else begin
      case (state_q)
        ST_RUN:
          if (sleep_req_i) state_q <= stby_sel_i ? ST_STBY : ST_SLEEP;
        ST_SLEEP:
          if (wake_irq_i || nmi_edge_i) state_q <= ST_RUN;
        ST_STBY:
          if (nmi_edge_i) begin
            state_q <= ST_SETTLE;
            cnt_q   <= settle_load(settle_sel_i, SETTLE_SHIFT);
          end
        default:
          if (cnt_q == '0) state_q <= ST_RUN;
          else             cnt_q   <= cnt_q - 1'b1;
      endcase
    end
  end

  assign state_o   = state_q;
  assign cpu_run_o = (state_q == ST_RUN);

  // R5
  release_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_run_o) |-> ($past(state_q) == ST_SLEEP) ||
                         ($past(state_q) == ST_SETTLE && $past(cnt_q) == '0));

  // R4
  stby_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STBY) |=> (state_q != ST_RUN));
endmodule

// File: rtl/lpc_bus_hold.sv
`timescale 1ns/1ps
module lpc_bus_hold #(
  parameter int ADDR_W = 16,
  parameter int STB_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lowpwr_i,
  input  logic              hold_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [STB_W-1:0]  strb_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_oe_o,
  output logic [STB_W-1:0]  strb_o,
  output logic              strb_oe_o
);
  logic [ADDR_W-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        last_q <= '0;
    else if (!lowpwr_i) last_q <= addr_i;
  end

  always_comb begin
    if (lowpwr_i) begin
      addr_o    = last_q;
      strb_o    = '1;
      addr_oe_o = hold_en_i;
      strb_oe_o = hold_en_i;
    end else begin
      addr_o    = addr_i;
      strb_o    = strb_i;
      addr_oe_o = 1'b1;
      strb_oe_o = 1'b1;
    end
  end

  // R9
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lowpwr_i && $past(lowpwr_i)) |-> $stable(addr_o));
endmodule

// File: rtl/lpc_ctrl.sv
`timescale 1ns/1ps
module lpc_ctrl
  import lpc_pkg::*;
#(
  parameter int unsigned SETTLE_SHIFT = 0,
  parameter int          ADDR_W       = 16,
  parameter int          STB_W        = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [7:0]        cfg_wdata_i,
  output logic [7:0]        cfg_rdata_o,
  output logic              illegal_o,
  input  logic              sleep_req_i,
  input  logic              wake_irq_i,
  input  logic              nmi_i,
  output logic              nmi_req_o,
  output logic              cpu_run_o,
  output logic              sleep_o,
  output logic              stby_o,
  output logic              ram_en_o,
  output logic              user_bit_o,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [STB_W-1:0]  cpu_strb_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_addr_oe_o,
  output logic [STB_W-1:0]  bus_strb_o,
  output logic              bus_strb_oe_o
);
  lpc_cfg_t   cfg;
  lpc_state_e state;
  logic       run;
  logic       nmi_edge;
  logic       lowpwr;

  lpc_sysreg u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .wdata_i   (cfg_wdata_i),
    .wr_ok_i   (run),
    .cfg_o     (cfg),
    .illegal_o (illegal_o)
  );

  lpc_nmi_edge u_nmi (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .nmi_i      (nmi_i),
    .rise_sel_i (cfg.nmi_rise),
    .edge_o     (nmi_edge)
  );

  lpc_pwr_fsm #(.SETTLE_SHIFT(SETTLE_SHIFT)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sleep_req_i  (sleep_req_i),
    .wake_irq_i   (wake_irq_i),
    .nmi_edge_i   (nmi_edge),
    .stby_sel_i   (cfg.stby_sel),
    .settle_sel_i (cfg.settle_sel),
    .state_o      (state),
    .cpu_run_o    (run)
  );

  // oscillator treated as stopped until settling completes
  assign lowpwr = (state == ST_STBY) || (state == ST_SETTLE);

  lpc_bus_hold #(.ADDR_W(ADDR_W), .STB_W(STB_W)) u_bus (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lowpwr_i  (lowpwr),
    .hold_en_i (cfg.hold_en),
    .addr_i    (cpu_addr_i),
    .strb_i    (cpu_strb_i),
    .addr_o    (bus_addr_o),
    .addr_oe_o (bus_addr_oe_o),
    .strb_o    (bus_strb_o),
    .strb_oe_o (bus_strb_oe_o)
  );

  assign cfg_rdata_o = cfg;
  assign nmi_req_o   = nmi_edge;
  assign cpu_run_o   = run;
  assign sleep_o     = (state == ST_SLEEP);
  assign stby_o      = (state == ST_STBY);
  assign ram_en_o    = cfg.ram_en;
  assign user_bit_o  = cfg.user_en;

  // R8
  hiz_stby_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stby_o && !cfg.hold_en) |-> (!bus_addr_oe_o && !bus_strb_oe_o));

  // R3
  sleep_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_o |-> !cpu_run_o && !stby_o);
endmodule

// File: tb/sim_lpc_ctrl.sv
`timescale 1ns/1ps
module sim_lpc_ctrl;
  localparam int SHIFT  = 6;
  localparam int ADDR_W = 16;
  localparam int STB_W  = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [7:0]        cfg_wdata = 8'h00;
  logic [7:0]        cfg_rdata;
  logic              illegal;
  logic              sleep_req = 1'b0;
  logic              wake_irq = 1'b0;
  logic              nmi = 1'b1;
  logic              nmi_req;
  logic              cpu_run, sleep_st, stby_st, ram_en, user_bit;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [STB_W-1:0]  cpu_strb = '0;
  logic [ADDR_W-1:0] bus_addr;
  logic              bus_addr_oe;
  logic [STB_W-1:0]  bus_strb;
  logic              bus_strb_oe;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  lpc_ctrl #(.SETTLE_SHIFT(SHIFT), .ADDR_W(ADDR_W), .STB_W(STB_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .illegal_o(illegal), .sleep_req_i(sleep_req),
    .wake_irq_i(wake_irq), .nmi_i(nmi), .nmi_req_o(nmi_req), .cpu_run_o(cpu_run),
    .sleep_o(sleep_st), .stby_o(stby_st), .ram_en_o(ram_en), .user_bit_o(user_bit),
    .cpu_addr_i(cpu_addr), .cpu_strb_i(cpu_strb), .bus_addr_o(bus_addr),
    .bus_addr_oe_o(bus_addr_oe), .bus_strb_o(bus_strb), .bus_strb_oe_o(bus_strb_oe)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic int exp_wait(input int code);
    int base;
    case (code)
      0: base = 8192;   1: base = 16384;  2: base = 32768;  3: base = 65536;
      4: base = 131072; 5: base = 262144; 6: base = 1024;   default: base = 262144;
    endcase
    return base >> SHIFT;
  endfunction

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic count_to_run(output int n);
    n = 0;
    while (!cpu_run && n < 20000) begin
      @(posedge clk); n++; @(negedge clk);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    cfg_we = 1'b1; cfg_wdata = d; @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic go_sleep;
    sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0;
  endtask

  task automatic t_reset;
    int n;
    rst_n = 1'b0; cycles(3); rst_n = 1'b1;
    chk("R1 rdata", cfg_rdata, 8'h09);
    chk("R1 ram_en", ram_en, 1);
    chk("R1 user_bit", user_bit, 1);
    chk("R1 illegal", illegal, 0);
    chk("R1 run held", cpu_run, 0);
    count_to_run(n);
    chk("R1 R5 reset wait", n, exp_wait(0));
  endtask

  task automatic t_fields;
    wr(8'h00); @(negedge clk);
    chk("R2 rdata 00", cfg_rdata, 8'h00);
    chk("R2 ram_en off", ram_en, 0);
    chk("R2 user_bit off", user_bit, 0);
    wr(8'hA6);
    chk("R2 rdata A6", cfg_rdata, 8'hA6);
    wr(8'h09);
    chk("R2 rdata 09", cfg_rdata, 8'h09);
    chk("R2 ram_en on", ram_en, 1);
    chk("R2 user_bit on", user_bit, 1);
  endtask

  task automatic t_nmi_req;
    nmi = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R7 no req at 1", nmi_req, 0);
    @(posedge clk); @(negedge clk);
    chk("R7 req at 2", nmi_req, 1);
    @(negedge clk);
    chk("R7 req one clock", nmi_req, 0);
    nmi = 1'b1; cycles(4);
    chk("R7 opposite edge no req", nmi_req, 0);
  endtask

  task automatic t_sleep_irq;
    int n;
    wr(8'h09);
    cpu_addr = 16'h0ABC; cpu_strb = 4'h5;
    go_sleep;
    chk("R3 sleep_o", sleep_st, 1);
    chk("R3 run low", cpu_run, 0);
    chk("R3 bus live in sleep", bus_addr, 16'h0ABC);
    cycles(5);
    chk("R3 stays asleep", sleep_st, 1);
    wake_irq = 1'b1;
    count_to_run(n);
    wake_irq = 1'b0;
    chk("R3 irq wake clocks", n, 1);
  endtask

  task automatic t_sleep_nmi;
    int n;
    go_sleep;
    nmi = 1'b0;
    count_to_run(n);
    chk("R7 nmi sleep wake clocks", n, 3);
    nmi = 1'b1; cycles(4);
  endtask

  task automatic t_write_blocked;
    int n;
    go_sleep;
    wr(8'hFF);
    wake_irq = 1'b1; count_to_run(n); wake_irq = 1'b0;
    chk("R10 write in sleep ignored", cfg_rdata, 8'h09);
    chk("R10 illegal untouched", illegal, 0);
  endtask

  task automatic t_stby(input int code, input bit rise, input bit hold, input string rq);
    int n;
    logic [7:0] v;
    v = {1'b1, 3'(code), 1'b1, rise, hold, 1'b1};
    wr(v);
    cpu_addr = 16'h1234; cpu_strb = 4'h2;
    @(negedge clk);
    go_sleep;
    chk({rq, " R4 stby_o"}, stby_st, 1);
    chk({rq, " R4 run low"}, cpu_run, 0);
    cpu_addr = 16'hFFFF; cpu_strb = 4'h0;
    @(negedge clk);
    if (hold) begin
      chk({rq, " R9 addr held"}, bus_addr, 16'h1234);
      chk({rq, " R9 strb high"}, bus_strb, 4'hF);
      chk({rq, " R9 oe"}, {bus_addr_oe, bus_strb_oe}, 2'b11);
    end else begin
      chk({rq, " R8 oe off"}, {bus_addr_oe, bus_strb_oe}, 2'b00);
    end
    if (rise) begin
      nmi = 1'b0; cycles(6);
      chk({rq, " R7 falling ignored"}, stby_st, 1);
      nmi = 1'b1;
    end else begin
      nmi = 1'b0;
    end
    count_to_run(n);
    chk({rq, " R5 stby wake clocks"}, n, exp_wait(code) + 3);
    nmi = 1'b1; cycles(4);
    chk({rq, " R3 bus live again"}, bus_addr, 16'hFFFF);
  endtask

  task automatic t_illegal;
    t_stby(7, 1'b0, 1'b1, "R6 code7");
    chk("R6 illegal set", illegal, 1);
    wr(8'h09);
    chk("R6 illegal sticky", illegal, 1);
    chk("R6 code7 readback cleared", cfg_rdata, 8'h09);
  endtask

  initial begin
    @(negedge clk);
    t_reset;
    t_fields;
    t_nmi_req;
    t_sleep_irq;
    t_sleep_nmi;
    t_write_blocked;
    t_stby(6, 1'b0, 1'b0, "R5 code6");
    t_stby(0, 1'b1, 1'b1, "R5 code0");
    t_stby(1, 1'b0, 1'b1, "R5 code1");
    t_stby(5, 1'b0, 1'b0, "R5 code5");
    t_illegal;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    total++; bad++;
    $display("FAIL watchdog all: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule